// File: doc/BRIEF.md
# Clear-on-Read Maskable Interrupt Aggregator

This block collects sixteen single-cycle event pulses from the rest of a peripheral chip into two 8-bit latched status registers. Each status register has an 8-bit enable register of the same layout. A bit that is both set and enabled pulls an active-low request line toward the host. The line stays low until the host reads the status register that holds the active bit.

The host reaches the registers through a simple synchronous port. It presents an address with a read or write strobe, and read data appears registered one cycle later. A status read returns the latched value and then clears only the bits that are enabled. Disabled events are still recorded and can be polled, but they never raise the request line. A read-only register returns a fixed version code.

Top module: `irq_agg_top`

## Requirements
- R1: `irqN` is 0 in every cycle in which at least one status bit and its matching enable bit are both 1, and 1 otherwise. The line reflects register state, so an enabled event pulse drives it low from the cycle after the pulse.
- R2: An event pulse on a disabled bit sets its status bit but leaves `irqN` high.
- R3: A read of a status register returns the value held before the read, one cycle after the strobe. The read then clears only the bits whose enable is 1. Bits whose enable is 0 keep their value.
- R4: If an event pulse arrives on a bit in the same cycle as a read of its status register, the bit is 1 after the read. The data returned is the value held before the read.
- R5: Register addresses are: 01h version, 03h status group 1, 04h status group 2, 05h enable group 1, 06h enable group 2. The enable registers read back the last value written. Version reads return the 5-bit code 06h in bits 4:0, with bits 7:5 equal to 0.
- R6: Writes to the version register and to the status registers have no effect on their read values.
- R7: After reset, enable group 1 is 00h and enable group 2 is 01h. Status group 1 is 00h and status group 2 is 01h, which is the power-on bit. `irqN` is therefore 0 after reset.
- R8: A read of any other address returns 00h and changes no status bit and no `irqN` level.
- R9: Event input bit i sets status bit i of its group and is gated by enable bit i. In group 1, bit 7 is FIFO error and bit 0 is CRC error, with TX-almost-full, TX-almost-empty, RX-almost-full, external, packet-sent and valid-packet in between. In group 2, bit 7 is sync detected and bit 0 is power-on, with valid-preamble, invalid-preamble, RSSI, wake-up timer, low battery and chip-ready in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtGrp1 | input | 8 | Event pulses for status group 1 |
| evtGrp2 | input | 8 | Event pulses for status group 2 |
| regAddr | input | 8 | Register address |
| regRdEn | input | 1 | Read strobe |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Registered read data, valid one cycle after the read strobe |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a new event that lands on a bit in the very cycle that its status register is being read and cleared. The pre-read value, the cleared bits and the surviving bit must all be told apart. The bench first latches a different enabled bit. It then issues the status read and the new pulse from the same falling edge, so both reach the same rising edge. The returned data is checked against the old value, and a second read shows that only the new bit survived. A similar setup covers bits that are latched while disabled: the bench reads them twice to show they are not cleared, then enables them afterwards to show that the request line falls.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int DATA_W  = 8;
  parameter int NUM_GRP = 2;

  // strobes from the address decoder to the register datapath
  typedef struct packed {
    logic [NUM_GRP-1:0] rdStat;
    logic [NUM_GRP-1:0] rdEnab;
    logic [NUM_GRP-1:0] wrEnab;
    logic               rdVer;
    logic               rdAny;
  } strobeT;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ADDR_VER  = 1,
  parameter int STAT_BASE = 3,
  parameter int ENAB_BASE = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  output strobeT            strobe
);
  localparam logic [ADDR_W-1:0] VerAddr = ADDR_W'(ADDR_VER);

  logic [NUM_GRP-1:0] statHit;
  logic [NUM_GRP-1:0] enabHit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_BASE + g);
    localparam logic [ADDR_W-1:0] EnabAddr = ADDR_W'(ENAB_BASE + g);
    assign statHit[g] = (regAddr == StatAddr);
    assign enabHit[g] = (regAddr == EnabAddr);
  end

  always_comb begin
    strobe.rdStat = statHit & {NUM_GRP{regRdEn}};
    strobe.rdEnab = enabHit & {NUM_GRP{regRdEn}};
    strobe.wrEnab = enabHit & {NUM_GRP{regWrEn}};
    strobe.rdVer  = regRdEn && (regAddr == VerAddr);
    strobe.rdAny  = regRdEn;
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int                          VER_W    = 5,
  parameter logic [VER_W-1:0]            VERSION  = 5'h06,
  parameter logic [NUM_GRP*DATA_W-1:0]   ENAB_RST = 16'h0100,
  parameter logic [NUM_GRP*DATA_W-1:0]   STAT_RST = 16'h0100
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_GRP-1:0][DATA_W-1:0] evt,
  input  logic [DATA_W-1:0]              wrData,
  input  strobeT                         strobe,
  output logic [DATA_W-1:0]              rdData,
  output logic                           irqN
);
  localparam logic [DATA_W-1:0] VerWord = {{(DATA_W-VER_W){1'b0}}, VERSION};

  logic [NUM_GRP-1:0][DATA_W-1:0] stat;
  logic [NUM_GRP-1:0][DATA_W-1:0] enab;
  logic [NUM_GRP-1:0]             grpActive;
  logic [DATA_W-1:0]              rdNext;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_reg
    logic [DATA_W-1:0] clrMask;
    assign clrMask = strobe.rdStat[g] ? enab[g] : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stat[g] <= STAT_RST[g*DATA_W +: DATA_W];
        enab[g] <= ENAB_RST[g*DATA_W +: DATA_W];
      end else begin
        // a fresh event overrides the read-clear of the same bit
        stat[g] <= (stat[g] & ~clrMask) | evt[g];
        if (strobe.wrEnab[g]) enab[g] <= wrData;
      end
    end

    assign grpActive[g] = |(stat[g] & enab[g]);

    // R2 R4
    event_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
      (evt[g] != '0) |=> ((stat[g] & $past(evt[g])) == $past(evt[g])));

    // R3
    keep_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.rdStat[g] |=>
        ((stat[g] & ~$past(enab[g])) & $past(stat[g])) == ($past(stat[g]) & ~$past(enab[g])));

    // R1
    enabled_evt_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((|(evt[g] & enab[g])) && !strobe.wrEnab[g]) |=> !irqN);
  end

  always_comb begin
    rdNext = '0;
    if (strobe.rdVer) rdNext = VerWord;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (strobe.rdStat[g]) rdNext = rdNext | stat[g];
      if (strobe.rdEnab[g]) rdNext = rdNext | enab[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdAny) rdData <= rdNext;
  end

  assign irqN = ~|grpActive;

  // R5
  version_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdVer |=> (rdData == VerWord));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdAny && !strobe.rdVer && (strobe.rdStat == '0) && (strobe.rdEnab == '0))
      |=> (rdData == '0));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter int               VER_W   = 5,
  parameter logic [VER_W-1:0] VERSION = 5'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        evtGrp1,
  input  logic [7:0]        evtGrp2,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              irqN
);
  strobeT                         strobe;
  logic [NUM_GRP-1:0][DATA_W-1:0] evt;

  assign evt[0] = evtGrp1;
  assign evt[1] = evtGrp2;

  irq_agg_ctrl #(
    .ADDR_W   (ADDR_W),
    .ADDR_VER (1),
    .STAT_BASE(3),
    .ENAB_BASE(5)
  ) ctrl_i (
    .regAddr(regAddr),
    .regRdEn(regRdEn),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  irq_agg_datapath #(
    .VER_W   (VER_W),
    .VERSION (VERSION),
    .ENAB_RST(16'h0100),
    .STAT_RST(16'h0100)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .evt   (evt),
    .wrData(regWrData),
    .strobe(strobe),
    .rdData(regRdData),
    .irqN  (irqN)
  );
endmodule

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtGrp1 = '0;
  logic [7:0] evtGrp2 = '0;
  logic [7:0] regAddr = '0;
  logic       regRdEn = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] data;
    string      tag;
  } expT;
  expT expQ[$];

  always #4 clk = ~clk;

  irq_agg_top dut_i (
    .clk(clk), .rstN(rstN), .evtGrp1(evtGrp1), .evtGrp2(evtGrp2),
    .regAddr(regAddr), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqN(irqN)
  );

  // monitor: compare read data 2 ns after the capturing edge
  always @(posedge clk) begin
    if (rstN && regRdEn) begin
      expT e;
      #2;
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expected item, got %02h exp none", regRdData);
      end else begin
        e = expQ.pop_front();
        if (regRdData !== e.data) begin
          fails++;
          $display("FAIL %s: read data %02h exp %02h", e.tag, regRdData, e.data);
        end
      end
    end
  end

  // one bus cycle: drive on falling edge, release on the next
  task automatic busCycle(input bit rd, input bit wr, input logic [7:0] addr,
                          input logic [7:0] wdata, input logic [7:0] e1,
                          input logic [7:0] e2, input logic [7:0] expRd,
                          input string tag);
    @(negedge clk);
    regRdEn = rd; regWrEn = wr; regAddr = addr; regWrData = wdata;
    evtGrp1 = e1; evtGrp2 = e2;
    if (rd) expQ.push_back('{expRd, tag});
    @(negedge clk);
    regRdEn = 1'b0; regWrEn = 1'b0; evtGrp1 = '0; evtGrp2 = '0;
  endtask

  task automatic rdReg(input logic [7:0] addr, input logic [7:0] expRd, input string tag);
    busCycle(1'b1, 1'b0, addr, 8'h00, 8'h00, 8'h00, expRd, tag);
  endtask

  task automatic wrReg(input logic [7:0] addr, input logic [7:0] data);
    busCycle(1'b0, 1'b1, addr, data, 8'h00, 8'h00, 8'h00, "");
  endtask

  task automatic pulse(input logic [7:0] e1, input logic [7:0] e2);
    busCycle(1'b0, 1'b0, 8'h00, 8'h00, e1, e2, 8'h00, "");
  endtask

  // checked right after a bus cycle ends, on a falling edge
  task automatic checkIrq(input logic expVal, input string tag);
    checks++;
    if (irqN !== expVal) begin
      fails++;
      $display("FAIL %s: irqN %b exp %b", tag, irqN, expVal);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R7 reset state
    checkIrq(1'b0, "R7");
    rdReg(8'h05, 8'h00, "R7");
    rdReg(8'h06, 8'h01, "R7");
    rdReg(8'h03, 8'h00, "R7");
    rdReg(8'h04, 8'h01, "R7");     // clears the enabled power-on bit
    checkIrq(1'b1, "R3");
    rdReg(8'h04, 8'h00, "R3");
    // R5 version
    rdReg(8'h01, 8'h06, "R5");
    // R6 writes to read-only registers
    wrReg(8'h01, 8'hFF);
    rdReg(8'h01, 8'h06, "R6");
    wrReg(8'h03, 8'hFF);
    rdReg(8'h03, 8'h00, "R6");
    // R2 disabled event latches silently
    pulse(8'h08, 8'h00);
    checkIrq(1'b1, "R2");
    rdReg(8'h03, 8'h08, "R2");
    rdReg(8'h03, 8'h08, "R3");     // disabled bit not cleared
    // R1 enabling an already latched bit asserts the line
    wrReg(8'h05, 8'h08);
    checkIrq(1'b0, "R1");
    rdReg(8'h03, 8'h08, "R1");
    checkIrq(1'b1, "R1");
    rdReg(8'h03, 8'h00, "R3");
    // R9 bit positions: FIFO error (bit 7) and CRC error (bit 0)
    wrReg(8'h05, 8'hFF);
    pulse(8'h81, 8'h00);
    checkIrq(1'b0, "R9");
    rdReg(8'h03, 8'h81, "R9");
    checkIrq(1'b1, "R9");
    // R4 event coinciding with read-clear
    pulse(8'h02, 8'h00);
    busCycle(1'b1, 1'b0, 8'h03, 8'h00, 8'h20, 8'h00, 8'h02, "R4");
    checkIrq(1'b0, "R4");
    rdReg(8'h03, 8'h20, "R4");
    checkIrq(1'b1, "R4");
    // R8 unmapped reads, group 2 with power-on disabled
    wrReg(8'h06, 8'h80);
    pulse(8'h00, 8'h81);
    checkIrq(1'b0, "R9");
    rdReg(8'h02, 8'h00, "R8");
    checkIrq(1'b0, "R8");
    rdReg(8'hFF, 8'h00, "R8");
    rdReg(8'h04, 8'h81, "R8");
    checkIrq(1'b1, "R3");
    rdReg(8'h04, 8'h01, "R3");
    // R5 enable readback
    rdReg(8'h05, 8'hFF, "R5");
    rdReg(8'h06, 8'h80, "R5");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule